// File: doc/BRIEF.md
# Double-Buffered Frame Sender over UART

This block sits between a converter readout controller and a serial link to a host. The readout side presents one 40-bit result word together with a one-cycle valid strobe. The block latches the word into a capture register. On the next cycle it moves the word into a separate transmit register, so the capture register is free again. The transmit register alone drives the serial line. It sends the word as five 8N1 bytes, lowest byte first.

Only one frame is ever stored for sending, and each frame has to leave the block before the next readout result arrives. A word that comes in while the sender still holds a frame is discarded, and a sticky overrun flag is raised. The baud period is a parameter counted in clock cycles. The default of 434 cycles gives about 230400 baud from a 100 MHz clock, so one frame of 50 line bits takes about 217 µs.

The sender is a four-state machine:

- IDLE: the line is high. On a load from the capture stage it goes to START.
- START: the line is low for one bit period. It then goes to DATA.
- DATA: eight bit periods, LSB first. After the eighth bit it goes to STOP.
- STOP: the line is high for one bit period. It then returns to START for the next byte, or to IDLE after the fifth byte.

Top module: `frame_uart_buffer`

## Requirements
- R1: While reset is high and right after it, tx is 1, busy is 0 and overrun is 0.
- R2: A word strobed at clock edge E0 while the block is idle is moved to the transmit register at edge E1. The start bit (tx=0) and busy=1 both begin right after E1.
- R3: The 40-bit word goes out as five bytes, bits 7:0 first and bits 39:32 last. Within each byte the data bits go out LSB first.
- R4: Each byte is a 0 start bit, then eight data bits, then a 1 stop bit. Every line bit lasts exactly CLKS_PER_BIT clock cycles.
- R5: busy stays high from the first start bit to the end of the fifth stop bit, which is exactly 50*CLKS_PER_BIT cycles. It then drops to 0.
- R6: A strobe that arrives while busy is high is dropped and sets overrun. The frame in progress is not changed, and the dropped word is never sent.
- R7: Once set, overrun stays at 1 through later clean frames until reset.
- R8: Whenever busy is 0, tx is 1.
- R9: A strobe in the cycle right after an accepted strobe is dropped and sets overrun. The first word is still sent intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 40 | Result word from the readout side |
| word_valid | input | 1 | One-cycle strobe qualifying word_in |
| tx | output | 1 | UART line, idles high |
| busy | output | 1 | High while a frame is on the line |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
The hardest cases to reach from the ports are a strobe that lands inside a frame at a chosen bit position, and a strobe that lands in the single cycle between capture and the start bit. The bench reaches the first by pulsing word_valid during the first cycle of line bit 23 of an ongoing frame. It reaches the second by holding word_valid for two cycles with different words. In both cases the bench then checks every line bit of the surviving frame, confirms that the line stays idle afterwards, and checks the overrun flag.

// File: rtl/frame_uart_pkg.sv
package frame_uart_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } ser_state_t;
endpackage

// File: rtl/fub_baud.sv
module fub_baud #(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fub_capture.sv
module fub_capture #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_valid,
    input  logic [W-1:0] word_in,
    input  logic         ser_idle,
    output logic         load,
    output logic [W-1:0] frame,
    output logic         overrun
);
    logic         cap_full;
    logic [W-1:0] cap_reg;
    logic         accept;

    assign accept = word_valid && !cap_full && ser_idle;
    assign load   = cap_full && ser_idle;
    assign frame  = cap_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_full <= 1'b0;
            cap_reg  <= '0;
            overrun  <= 1'b0;
        end else begin
            if (accept) begin
                cap_reg  <= word_in;
                cap_full <= 1'b1;
            end else if (load) begin
                cap_full <= 1'b0;
            end
            if (word_valid && !accept) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/fub_serializer.sv
module fub_serializer
    import frame_uart_pkg::*;
#(
    parameter int NBYTES       = 5,
    parameter int CLKS_PER_BIT = 434
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [NBYTES*BYTE_BITS-1:0] frame,
    output logic                        tx,
    output logic                        busy,
    output logic                        idle
);
    localparam int W  = NBYTES * BYTE_BITS;
    localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BW-1:0] LAST_BYTE = BW'(NBYTES - 1);

    ser_state_t    state, state_nx;
    logic [W-1:0]  shreg;
    logic [2:0]    bit_cnt;
    logic [BW-1:0] byte_cnt;
    logic          tick;

    fub_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (state != S_IDLE),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (load) state_nx = S_START;
            S_START: if (tick) state_nx = S_DATA;
            S_DATA:  if (tick && bit_cnt == 3'd7) state_nx = S_STOP;
            S_STOP:  if (tick) state_nx = (byte_cnt == LAST_BYTE) ? S_IDLE : S_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (load) begin
                    shreg    <= frame;
                    bit_cnt  <= '0;
                    byte_cnt <= '0;
                end
                S_START: ;
                S_DATA: if (tick) begin
                    shreg   <= shreg >> 1;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                S_STOP: if (tick) byte_cnt <= byte_cnt + 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:  tx = 1'b1;
            S_START: tx = 1'b0;
            S_DATA:  tx = shreg[0];
            S_STOP:  tx = 1'b1;
        endcase
        busy = (state != S_IDLE);
        idle = (state == S_IDLE);
    end
endmodule

// File: rtl/frame_uart_buffer.sv
module frame_uart_buffer
    import frame_uart_pkg::*;
#(
    parameter int NBYTES       = 5,
    parameter int CLKS_PER_BIT = 434,
    localparam int W           = NBYTES * BYTE_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word_in,
    input  logic         word_valid,
    output logic         tx,
    output logic         busy,
    output logic         overrun
);
    logic         load;
    logic         ser_idle;
    logic [W-1:0] frame;

    fub_capture #(.W(W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word_in    (word_in),
        .ser_idle   (ser_idle),
        .load       (load),
        .frame      (frame),
        .overrun    (overrun)
    );

    fub_serializer #(.NBYTES(NBYTES), .CLKS_PER_BIT(CLKS_PER_BIT)) u_ser (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .frame (frame),
        .tx    (tx),
        .busy  (busy),
        .idle  (ser_idle)
    );
endmodule

// File: rtl/frame_uart_buffer_chk.sv
module frame_uart_buffer_chk #(
    parameter int NBYTES       = 5,
    parameter int CLKS_PER_BIT = 434
) (
    input logic clk,
    input logic rst,
    input logic word_valid,
    input logic tx,
    input logic busy,
    input logic overrun
);
    localparam int FRAME_CYC = NBYTES * 10 * CLKS_PER_BIT;
    localparam int CNTW      = $clog2(FRAME_CYC + 2);

    logic [CNTW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    p_idle_high_r8: assert property (@(posedge clk) disable iff (rst) !busy |-> tx);
    p_start_first_r2: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !tx);
    p_stop_last_r4: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(tx));
    p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == CNTW'(FRAME_CYC)));
    p_drop_flag_r6: assert property (@(posedge clk) disable iff (rst) (word_valid && busy) |=> overrun);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst) overrun |=> overrun);
endmodule

bind frame_uart_buffer frame_uart_buffer_chk #(
    .NBYTES(NBYTES), .CLKS_PER_BIT(CLKS_PER_BIT)
) u_chk (
    .clk(clk), .rst(rst), .word_valid(word_valid),
    .tx(tx), .busy(busy), .overrun(overrun)
);

// File: tb/frame_uart_buffer_bench.sv
module frame_uart_buffer_bench;
    localparam int DIV = 4;
    localparam int NB  = 5;
    localparam int W   = NB * 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] word_in = '0;
    logic         word_valid = 1'b0;
    logic         tx, busy, overrun;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    always #4 clk = ~clk;

    frame_uart_buffer #(.NBYTES(NB), .CLKS_PER_BIT(DIV)) u_frame_uart_buffer (
        .clk(clk), .rst(rst), .word_in(word_in), .word_valid(word_valid),
        .tx(tx), .busy(busy), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        int p = k % 10;
        int b = k / 10;
        if (p == 0) return 1'b0;
        if (p == 9) return 1'b1;
        return w[b*8 + p - 1];
    endfunction

    // inj_k < 0: no mid-frame strobe; b2b: strobe held two cycles
    task automatic run_frame(input logic [W-1:0] w, input int inj_k, input logic [W-1:0] w2,
                             input bit b2b, input bit exp_ovr);
        @(negedge clk);
        word_in = w; word_valid = 1'b1;
        @(negedge clk);
        if (b2b) begin
            word_in = w2;
            @(negedge clk);
            word_valid = 1'b0;
        end else begin
            word_valid = 1'b0;
            @(negedge clk);
        end
        check(tx == 1'b0 && busy == 1'b1, "R2 start", {tx, busy}, 2'b01);
        for (int k = 0; k < NB*10; k++) begin
            check(tx == exp_bit(w, k), (k % 10 == 0 || k % 10 == 9) ? "R4 framing" : "R3 data",
                  tx, exp_bit(w, k));
            if (k == inj_k) begin
                word_in = w2; word_valid = 1'b1;
                @(negedge clk);
                word_valid = 1'b0;
                repeat (DIV-2) @(negedge clk);
            end else begin
                repeat (DIV-1) @(negedge clk);
            end
            check(tx == exp_bit(w, k) && busy == 1'b1, "R4 width/R5 busy", {tx, busy}, {exp_bit(w, k), 1'b1});
            @(negedge clk);
        end
        check(busy == 1'b0 && tx == 1'b1, "R5 end", {busy, tx}, 2'b01);
        check(overrun == exp_ovr, "R6/R7/R9 overrun", overrun, exp_ovr);
        repeat (3*DIV) @(negedge clk);
        check(tx == 1'b1 && busy == 1'b0, "R6/R8 idle line", {tx, busy}, 2'b10);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(tx == 1'b1 && busy == 1'b0 && overrun == 1'b0, "R1 in reset", {tx, busy, overrun}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check(tx == 1'b1 && busy == 1'b0 && overrun == 1'b0, "R1 after reset", {tx, busy, overrun}, 3'b100);
    endtask

    initial begin
        do_reset();
        run_frame(40'h0, -1, '0, 1'b0, 1'b0);
        run_frame(40'hFF_FFFF_FFFF, -1, '0, 1'b0, 1'b0);
        run_frame(40'hA5_5A_C3_3C_01, -1, '0, 1'b0, 1'b0);
        for (int i = 0; i < W; i++) run_frame(40'h1 << i, -1, '0, 1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            logic [W-1:0] w;
            w = {8'(i*37+1), 8'(i*11), 8'(~i), 8'(i<<3), 8'(i*97+5)};
            run_frame(w, -1, '0, 1'b0, 1'b0);
        end
        // R6: strobe during bit 23
        run_frame(40'h12_3456_789A, 23, 40'hFF_0000_FFFF, 1'b0, 1'b1);
        // R7: flag persists through a clean frame
        run_frame(40'h0F_0F0F_0F0F, -1, '0, 1'b0, 1'b1);
        do_reset();
        // R9: strobe in the cycle after acceptance
        run_frame(40'h80_C0E0_F001, -1, 40'h55_5555_5555, 1'b1, 1'b1);
        do_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule